// File: doc/BRIEF.md
# Pipeline Precise Exception Controller

This block turns the per-stage fault flags of a five-stage in-order pipeline into one precise exception. Each of the fetch, decode, execute and memory stages reports its own faults together with the program counter of the instruction it holds. The writeback stage cannot fault, so it has no input here. In any cycle the controller picks the oldest faulting instruction. It squashes that instruction and every younger one by raising per-stage flush lines, so the pipeline registers load bubbles at the next clock edge. It also steers fetch to a fixed handler address. Older instructions keep running and complete.

At that same edge the controller stores the faulting instruction's address in an exception-PC register and a reason code in a 32-bit cause register. A small read port lets a move-from-coprocessor instruction copy either register into a general register. The handler can then return to the faulting instruction with a register jump. The controller also detects signed add overflow itself from the execute stage's operands and result.

Top module: `exc_ctrl`

## Requirements
- R1: A fetch page fault (`if_pgflt`) alone raises `flush_if` only. At the next edge the cause register becomes code 0x04 in bits 6:2, and the exception PC becomes `if_pc`.
- R2: An illegal opcode in decode (`id_badop`) alone raises `flush_if` and `flush_id`. It records code 0x0A and `id_pc`.
- R3: Overflow is flagged only when `ex_trapv` is 1, `ex_opa` and `ex_opb` have the same sign, and `ex_sum`'s sign differs from theirs. It records code 0x0C. With `ex_trapv` at 0, no operand values raise an exception.
- R4: A divide by zero (`ex_divz`) records code 0x0D. If overflow and divide by zero are both flagged in the same cycle, code 0x0C is recorded.
- R5: A memory-stage address fault (`mem_addrflt`) records code 0x05 and `mem_pc`, and raises all four flush lines.
- R6: When several stages fault together, the oldest one wins (memory, then execute, then decode, then fetch). The exception PC and cause come from the winner, and the younger faults are dropped.
- R7: Flush lines cover the winning stage and every younger stage only. A stage older than the winner, in particular memory on an execute fault, is never flushed.
- R8: `redirect` is 1 in exactly the cycles in which some stage faults. `redirect_pc` then equals the `HANDLER_PC` parameter.
- R9: The exception PC and cause registers change only at the edge that ends a faulting cycle. They hold their values through cycles with no fault.
- R10: Every cause register bit outside 6:2 reads as zero.
- R11: `mv_data` returns the exception PC when `mv_sel` is 0 and the cause register (low `XLEN` bits) when `mv_sel` is 1, in the same cycle.
- R12: While `rst_n` is low, both registers are zero. With no fault flags, all flush lines and `redirect` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| if_pc | input | XLEN | PC of the instruction in fetch |
| if_pgflt | input | 1 | Instruction page fault |
| id_pc | input | XLEN | PC of the instruction in decode |
| id_badop | input | 1 | Undefined or illegal opcode |
| ex_pc | input | XLEN | PC of the instruction in execute |
| ex_trapv | input | 1 | Execute instruction traps on signed overflow |
| ex_opa | input | XLEN | Adder operand A |
| ex_opb | input | XLEN | Adder operand B |
| ex_sum | input | XLEN | Adder result |
| ex_divz | input | 1 | Division by zero |
| mem_pc | input | XLEN | PC of the instruction in memory |
| mem_addrflt | input | 1 | Data page fault or illegal/protected address |
| mv_sel | input | 1 | Read select: 0 exception PC, 1 cause |
| mv_data | output | XLEN | Read data for the move-from-coprocessor operation |
| flush_if | output | 1 | Replace the fetch-stage instruction with a bubble |
| flush_id | output | 1 | Replace the decode-stage instruction with a bubble |
| flush_ex | output | 1 | Replace the execute-stage instruction with a bubble |
| flush_mem | output | 1 | Replace the memory-stage instruction with a bubble |
| redirect | output | 1 | Load the fetch PC from `redirect_pc` |
| redirect_pc | output | XLEN | Handler address |

## Verification
The bench builds the controller with `XLEN` = 8 and `HANDLER_PC` = 8'hC4. At this width every pair of adder operands can be swept, with `ex_trapv` both set and clear, and the expected overflow is computed from signed integer arithmetic. All 32 combinations of the five fault sources are applied with distinct PCs per stage. For each one, the bench checks the winner, the flush pattern, the redirect, the captured registers, and that the registers then hold through an idle cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned NSTG = 4;
  localparam int unsigned CODE_W = 5;

  typedef enum logic [1:0] {
    STG_IF  = 2'd0,
    STG_ID  = 2'd1,
    STG_EX  = 2'd2,
    STG_MEM = 2'd3
  } stage_e;

  localparam logic [CODE_W-1:0] CODE_IPF  = 5'h04;
  localparam logic [CODE_W-1:0] CODE_ILL  = 5'h0A;
  localparam logic [CODE_W-1:0] CODE_OVF  = 5'h0C;
  localparam logic [CODE_W-1:0] CODE_DIVZ = 5'h0D;
  localparam logic [CODE_W-1:0] CODE_DADR = 5'h05;

  localparam int unsigned CODE_LSB = 2;
endpackage

// File: rtl/exc_ovf_det.sv
module exc_ovf_det #(
  parameter int unsigned XLEN = 32
) (
  input  logic            en,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] sum,
  output logic            ovf
);
  localparam int unsigned MSB = XLEN - 1;

  logic same_sign;
  logic flipped;

  always_comb begin
    same_sign = (opa[MSB] == opb[MSB]);
    flipped   = (sum[MSB] != opa[MSB]);
    ovf       = en & same_sign & flipped;
  end
endmodule

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [NSTG-1:0]             flt,
  input  logic [NSTG-1:0][XLEN-1:0]   pcs,
  input  logic [NSTG-1:0][CODE_W-1:0] codes,
  output logic                        take,
  output logic [XLEN-1:0]             win_pc,
  output logic [CODE_W-1:0]           win_code,
  output logic [NSTG-1:0]             flush
);
  // Flush mask is a thermometer: stage s is squashed when it or any older stage faults.
  for (genvar s = 0; s < NSTG; s++) begin : g_flush
    assign flush[s] = |flt[NSTG-1:s];
  end

  always_comb begin
    take     = |flt;
    win_pc   = '0;
    win_code = '0;
    // Ascending scan; a later (older) stage overrides a younger one.
    for (int s = 0; s < NSTG; s++) begin
      if (flt[s]) begin
        win_pc   = pcs[s];
        win_code = codes[s];
      end
    end
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [CODE_W-1:0] code_in,
  output logic [XLEN-1:0]   epc_q,
  output logic [31:0]       cause_q
);
  localparam int unsigned HI_W = 32 - CODE_W - CODE_LSB;

  logic [XLEN-1:0] epc_d;
  logic [31:0]     cause_d;

  always_comb begin
    epc_d   = epc_q;
    cause_d = cause_q;
    if (take) begin
      epc_d   = pc_in;
      cause_d = {{HI_W{1'b0}}, code_in, {CODE_LSB{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (take) begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned    XLEN       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = XLEN'(32'h8000_0180)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] if_pc,
  input  logic            if_pgflt,
  input  logic [XLEN-1:0] id_pc,
  input  logic            id_badop,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            ex_trapv,
  input  logic [XLEN-1:0] ex_opa,
  input  logic [XLEN-1:0] ex_opb,
  input  logic [XLEN-1:0] ex_sum,
  input  logic            ex_divz,
  input  logic [XLEN-1:0] mem_pc,
  input  logic            mem_addrflt,
  input  logic            mv_sel,
  output logic [XLEN-1:0] mv_data,
  output logic            flush_if,
  output logic            flush_id,
  output logic            flush_ex,
  output logic            flush_mem,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc
);
  logic                        ex_ovf;
  logic                        ex_flt;
  logic [CODE_W-1:0]           ex_code;
  logic [NSTG-1:0]             flt;
  logic [NSTG-1:0][XLEN-1:0]   pcs;
  logic [NSTG-1:0][CODE_W-1:0] codes;
  logic                        take;
  logic [XLEN-1:0]             win_pc;
  logic [CODE_W-1:0]           win_code;
  logic [NSTG-1:0]             flush;
  logic [XLEN-1:0]             epc_q;
  logic [31:0]                 cause_q;

  exc_ovf_det #(.XLEN(XLEN)) u_ovf (
    .en  (ex_trapv),
    .opa (ex_opa),
    .opb (ex_opb),
    .sum (ex_sum),
    .ovf (ex_ovf)
  );

  always_comb begin
    ex_flt  = ex_ovf | ex_divz;
    ex_code = ex_ovf ? CODE_OVF : CODE_DIVZ;

    flt[STG_IF]    = if_pgflt;
    flt[STG_ID]    = id_badop;
    flt[STG_EX]    = ex_flt;
    flt[STG_MEM]   = mem_addrflt;

    pcs[STG_IF]    = if_pc;
    pcs[STG_ID]    = id_pc;
    pcs[STG_EX]    = ex_pc;
    pcs[STG_MEM]   = mem_pc;

    codes[STG_IF]  = CODE_IPF;
    codes[STG_ID]  = CODE_ILL;
    codes[STG_EX]  = ex_code;
    codes[STG_MEM] = CODE_DADR;
  end

  exc_prio #(.XLEN(XLEN)) u_prio (
    .flt      (flt),
    .pcs      (pcs),
    .codes    (codes),
    .take     (take),
    .win_pc   (win_pc),
    .win_code (win_code),
    .flush    (flush)
  );

  exc_regs #(.XLEN(XLEN)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .pc_in   (win_pc),
    .code_in (win_code),
    .epc_q   (epc_q),
    .cause_q (cause_q)
  );

  always_comb begin
    flush_if    = flush[STG_IF];
    flush_id    = flush[STG_ID];
    flush_ex    = flush[STG_EX];
    flush_mem   = flush[STG_MEM];
    redirect    = take;
    redirect_pc = HANDLER_PC;
    mv_data     = mv_sel ? cause_q[XLEN-1:0] : epc_q;
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = XLEN'(32'h8000_0180)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            if_pgflt,
  input logic            id_badop,
  input logic            mem_addrflt,
  input logic [XLEN-1:0] mem_pc,
  input logic            flush_if,
  input logic            flush_id,
  input logic            flush_ex,
  input logic            flush_mem,
  input logic            redirect,
  input logic [XLEN-1:0] redirect_pc,
  input logic [XLEN-1:0] epc_q,
  input logic [31:0]     cause_q
);
  p_flush_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_mem |-> flush_ex) and (flush_ex |-> flush_id) and (flush_id |-> flush_if));

  p_mem_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_addrflt |-> !flush_mem);

  p_handler_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (redirect_pc == HANDLER_PC));

  p_redirect_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (if_pgflt || id_badop || mem_addrflt) |-> (redirect && flush_if));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> ($stable(epc_q) && $stable(cause_q)));

  p_mem_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && mem_addrflt) |=> (epc_q == $past(mem_pc) && cause_q[6:2] == 5'h05));

  p_cause_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q[31:7] == '0) && (cause_q[1:0] == 2'b00));
endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .if_pgflt    (if_pgflt),
  .id_badop    (id_badop),
  .mem_addrflt (mem_addrflt),
  .mem_pc      (mem_pc),
  .flush_if    (flush_if),
  .flush_id    (flush_id),
  .flush_ex    (flush_ex),
  .flush_mem   (flush_mem),
  .redirect    (redirect),
  .redirect_pc (redirect_pc),
  .epc_q       (epc_q),
  .cause_q     (cause_q)
);

// File: tb/exc_ctrl_tb_top.sv
module exc_ctrl_tb_top;
  localparam int unsigned W = 8;
  localparam logic [W-1:0] HPC = 8'hC4;

  logic clk, rst_n;
  logic [W-1:0] if_pc, id_pc, ex_pc, mem_pc, ex_opa, ex_opb, ex_sum, mv_data, redirect_pc;
  logic if_pgflt, id_badop, ex_trapv, ex_divz, mem_addrflt, mv_sel;
  logic flush_if, flush_id, flush_ex, flush_mem, redirect;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  exc_ctrl #(.XLEN(W), .HANDLER_PC(HPC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .if_pc(if_pc), .if_pgflt(if_pgflt),
    .id_pc(id_pc), .id_badop(id_badop),
    .ex_pc(ex_pc), .ex_trapv(ex_trapv), .ex_opa(ex_opa), .ex_opb(ex_opb),
    .ex_sum(ex_sum), .ex_divz(ex_divz),
    .mem_pc(mem_pc), .mem_addrflt(mem_addrflt),
    .mv_sel(mv_sel), .mv_data(mv_data),
    .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex), .flush_mem(flush_mem),
    .redirect(redirect), .redirect_pc(redirect_pc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic read_regs(output logic [W-1:0] epc, output logic [W-1:0] cause);
    mv_sel = 1'b0; #1 epc = mv_data;
    mv_sel = 1'b1; #1 cause = mv_data;
    mv_sel = 1'b0;
  endtask

  task automatic idle_inputs();
    if_pgflt = 0; id_badop = 0; ex_trapv = 0; ex_divz = 0; mem_addrflt = 0;
    ex_opa = 0; ex_opb = 0; ex_sum = 0;
  endtask

  initial begin
    logic [W-1:0] e_epc, e_cause, a_epc, a_cause;
    rst_n = 1'b0; mv_sel = 1'b0;
    if_pc = 0; id_pc = 0; ex_pc = 0; mem_pc = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    read_regs(a_epc, a_cause);
    chk(a_epc == 0, "R12 epc in reset", a_epc, 0);
    chk(a_cause == 0, "R12 cause in reset", a_cause, 0);
    chk({redirect, flush_if, flush_id, flush_ex, flush_mem} == 0, "R12 no flush idle",
        {redirect, flush_if, flush_id, flush_ex, flush_mem}, 0);
    rst_n = 1'b1;
    e_epc = 0; e_cause = 0;

    // All combinations of the five fault sources.
    for (int m = 0; m < 32; m++) begin
      bit f_if, f_id, f_ov, f_dz, f_mem, any;
      logic [4:0] code;
      logic [W-1:0] wpc;
      logic [3:0] efl;
      @(negedge clk);
      f_if = m[0]; f_id = m[1]; f_ov = m[2]; f_dz = m[3]; f_mem = m[4];
      if_pc = W'(m); id_pc = W'(m + 64); ex_pc = W'(m + 128); mem_pc = W'(m + 192);
      if_pgflt = f_if; id_badop = f_id; ex_divz = f_dz; mem_addrflt = f_mem;
      ex_trapv = 1'b1;
      if (f_ov) begin ex_opa = 8'h7F; ex_opb = 8'h01; ex_sum = 8'h80; end
      else      begin ex_opa = 8'h01; ex_opb = 8'h01; ex_sum = 8'h02; end
      any = f_if | f_id | f_ov | f_dz | f_mem;
      if (f_mem)             begin code = 5'h05; wpc = mem_pc; efl = 4'b1111; end
      else if (f_ov)         begin code = 5'h0C; wpc = ex_pc;  efl = 4'b0111; end
      else if (f_dz)         begin code = 5'h0D; wpc = ex_pc;  efl = 4'b0111; end
      else if (f_id)         begin code = 5'h0A; wpc = id_pc;  efl = 4'b0011; end
      else if (f_if)         begin code = 5'h04; wpc = if_pc;  efl = 4'b0001; end
      else                   begin code = 5'h00; wpc = e_epc;  efl = 4'b0000; end
      #5;
      // R7 thermometer flush, R1/R2/R5 patterns per stage
      chk({flush_mem, flush_ex, flush_id, flush_if} == efl, "R7 flush mask (R1 R2 R5)",
          {flush_mem, flush_ex, flush_id, flush_if}, efl);
      chk(redirect == any, "R8 redirect", redirect, any);
      if (any) chk(redirect_pc == HPC, "R8 handler pc", redirect_pc, HPC);
      @(posedge clk); #5;
      if (any) begin e_epc = wpc; e_cause = W'({code, 2'b00}); end
      read_regs(a_epc, a_cause);
      chk(a_epc == e_epc, "R6 epc of winner", a_epc, e_epc);
      chk(a_cause == e_cause, "R4 R10 cause of winner", a_cause, e_cause);
      // Idle cycle: registers must hold (R9).
      @(negedge clk);
      idle_inputs();
      #5;
      chk(redirect == 0, "R8 no redirect idle", redirect, 0);
      @(posedge clk); #5;
      read_regs(a_epc, a_cause);
      chk(a_epc == e_epc, "R9 epc hold", a_epc, e_epc);
      chk(a_cause == e_cause, "R9 cause hold", a_cause, e_cause);
    end

    // R11 read select on a known capture.
    @(negedge clk);
    ex_pc = 8'h5A; ex_divz = 1'b1;
    @(posedge clk); #5;
    mv_sel = 1'b0; #1 chk(mv_data == 8'h5A, "R11 sel0 epc", mv_data, 8'h5A);
    mv_sel = 1'b1; #1 chk(mv_data == 8'h34, "R11 sel1 cause", mv_data, 8'h34);
    mv_sel = 1'b0;
    @(negedge clk); idle_inputs();

    // R3 overflow sweep over all operand pairs, trapping on and off.
    for (int t = 0; t < 2; t++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          int sa, sb, s;
          bit exp_ov;
          sa = (a >= 128) ? a - 256 : a;
          sb = (b >= 128) ? b - 256 : b;
          s = sa + sb;
          exp_ov = (t == 1) && (s > 127 || s < -128);
          ex_trapv = (t == 1); ex_opa = W'(a); ex_opb = W'(b); ex_sum = W'(a + b);
          #1;
          if (redirect != exp_ov)
            chk(0, "R3 overflow detect", redirect, exp_ov);
          else
            n_run++;
        end
      end
    end
    idle_inputs();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule